// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a synchronous front end for an external asynchronous static RAM of 65,536 words by 16 bits. It takes one word request at a time from an internal valid/ready bus and turns it into the RAM's address, its active-low chip, write and output enables, and an active-low select for each byte lane. The data bus is bidirectional, so it leaves the block as three signals: a data-out word, a drive-enable flag and a data-in word, which the pad logic outside the block combines.

Each phase of an access is counted in system clock cycles, and each count is set by its own parameter. These are the read access window, the write setup, the write-enable pulse and the read-to-write turnaround gap. Writes are controlled by the write-enable strobe, and a per-byte mask selects which lanes take part. After a read, the block holds back its data drivers for a gap, so it never drives the bus while the RAM may still be driving it. Read data is registered and returned with a single-cycle valid pulse. Writes return no response.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, the chip, write and output enables and both byte selects are high, the data drivers are off, `req_ready_o` is high and `rsp_valid_o` is low.
- R2: A read accepted with a nonzero mask holds chip enable and output enable low and write enable high for exactly RD_CYC cycles, starting in the cycle after acceptance. During that time it presents the request address. Mask bit 0 pulls `sram_bs_no[0]` (data bits 7:0) low, and mask bit 1 pulls `sram_bs_no[1]` (data bits 15:8) low.
- R3: At the end of the read window, `sram_dq_i` is captured. `rsp_valid_o` is then high for exactly one cycle, the first cycle after the strobes are released. Byte lanes not selected by the mask read back as zero.
- R4: After a read, `req_ready_o` stays low for TURN_CYC cycles after the strobes are released. The data drivers are never enabled while output enable is low.
- R5: A write accepted with a nonzero mask first drives the data with chip enable low and write enable high for WR_SU_CYC cycles. Write enable is then low for WR_PW_CYC cycles. One further cycle follows with write enable high while chip enable, the selects and the data are held. After that, everything is released and the block is idle.
- R6: A write changes only the byte lanes set in its mask. The other lane of the addressed word keeps its previous contents.
- R7: A request with mask zero never asserts chip enable, and the block is ready again in the next cycle. A read with mask zero returns zero with `rsp_valid_o` high in the next cycle.
- R8: Writes never raise `rsp_valid_o`, and output enable stays high throughout a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | High only while idle; a request is accepted when valid and ready are both high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte mask, active high; bit 0 selects bits 7:0 |
| rsp_valid_o | output | 1 | One-cycle read response pulse |
| rsp_rdata_o | output | 16 | Read data, unselected lanes zero |
| sram_addr_o | output | 16 | RAM address |
| sram_ce_no | output | 1 | RAM chip enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_bs_no | output | 2 | Byte selects, active low; bit 0 lower lane, bit 1 upper lane |
| sram_dq_o | output | 16 | Data to drive onto the RAM bus |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | 16 | Data sampled from the RAM bus |

## Verification
Suppose the phase counter or the state register goes wrong. The effect shows at the strobe pins within one cycle: a window that is one cycle short or long, write enable falling without driven data, or the drivers switching on while output enable is still low. The bench compares every strobe and the ready flag against an expected timeline on every clock, so a single-cycle shift is reported in the cycle where it occurs. Lane masking errors show up later, as wrong bytes in read-back words, and a behavioural RAM on the bench supplies filler data on unselected lanes so that missing masking becomes visible.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_TURN, ST_WR_SU, ST_WR_PW, ST_WR_END
  } ctrl_state_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R2
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic [LANES-1:0]  be_i,
  output logic [LANES-1:0]  sel_no,
  output logic [DATA_W-1:0] bit_mask_o
);
  localparam int unsigned LANE_W = DATA_W / LANES;

  assign sel_no = ~be_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bit_mask_o[l*LANE_W +: LANE_W] = {LANE_W{be_i[l]}};
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= cap_i;
      if (cap_i) rsp_data_o <= data_i & mask_i;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LANES     = 2,
  parameter int unsigned RD_CYC    = 3,
  parameter int unsigned WR_SU_CYC = 1,
  parameter int unsigned WR_PW_CYC = 2,
  parameter int unsigned TURN_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [LANES-1:0]  sram_bs_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned MAX_C = max4(RD_CYC, WR_SU_CYC, WR_PW_CYC, TURN_CYC);
  localparam int unsigned CNT_W = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  ctrl_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] dq_q;
  logic              ce_n_q, we_n_q, oe_n_q, dq_oe_q;

  logic              accept, zero_mask, tmr_done, tmr_load, cap;
  logic [CNT_W-1:0]  tmr_val;
  logic [DATA_W-1:0] lane_mask, cap_mask;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign zero_mask   = (req_be_i == '0);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept && !zero_mask) begin
        tmr_load = 1'b1;
        tmr_val  = req_write_i ? CNT_W'(WR_SU_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      ST_RD:    if (tmr_done) begin tmr_load = 1'b1; tmr_val = CNT_W'(TURN_CYC - 1);  end
      ST_WR_SU: if (tmr_done) begin tmr_load = 1'b1; tmr_val = CNT_W'(WR_PW_CYC - 1); end
      default: ;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
  );

  sram_lane_sel #(.LANES(LANES), .DATA_W(DATA_W)) u_sel (
    .be_i(be_q), .sel_no(sram_bs_no), .bit_mask_o(lane_mask)
  );

  // capture at end of read window, or return zero at once for an empty mask
  assign cap      = ((state_q == ST_RD) && tmr_done) ||
                    (accept && zero_mask && !req_write_i);
  assign cap_mask = (state_q == ST_RD) ? lane_mask : '0;

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .cap_i(cap), .mask_i(cap_mask), .data_i(sram_dq_i),
    .rsp_valid_o, .rsp_data_o(rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      dq_q    <= '0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept && !zero_mask) begin
          addr_q <= req_addr_i;
          be_q   <= req_be_i;
          ce_n_q <= 1'b0;
          if (req_write_i) begin
            dq_q    <= req_wdata_i;
            dq_oe_q <= 1'b1;
            state_q <= ST_WR_SU;
          end else begin
            oe_n_q  <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: if (tmr_done) begin
          ce_n_q  <= 1'b1;
          oe_n_q  <= 1'b1;
          be_q    <= '0;
          state_q <= ST_TURN;
        end
        ST_TURN: if (tmr_done) state_q <= ST_IDLE;
        ST_WR_SU: if (tmr_done) begin
          we_n_q  <= 1'b0;
          state_q <= ST_WR_PW;
        end
        ST_WR_PW: if (tmr_done) begin
          we_n_q  <= 1'b1;
          state_q <= ST_WR_END;
        end
        ST_WR_END: begin
          ce_n_q  <= 1'b1;
          be_q    <= '0;
          dq_oe_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sram_addr_o  = addr_q;
  assign sram_ce_no   = ce_n_q;
  assign sram_we_no   = we_n_q;
  assign sram_oe_no   = oe_n_q;
  assign sram_dq_o    = dq_q;
  assign sram_dq_oe_o = dq_oe_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o
                     && (sram_bs_no == '1)));
  // R4
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> !sram_dq_oe_o);
  // R4
  drv_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> $past(sram_oe_no));
  // R5
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && sram_dq_oe_o && sram_oe_no));
  // R5
  we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (!sram_ce_no && sram_dq_oe_o));
  // R3
  rsp_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (sram_ce_no && sram_oe_no));
endmodule

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;
  localparam int RD = 3, SU = 1, PW = 2, TG = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, sram_addr, sram_dq_o, sram_dq_i;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [1:0]  bs_n;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  logic [15:0] ram [int];
  logic [15:0] ref_mem [int];

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.RD_CYC(RD), .WR_SU_CYC(SU), .WR_PW_CYC(PW), .TURN_CYC(TG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_be_i(req_be), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(sram_addr), .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n),
    .sram_bs_no(bs_n), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(sram_dq_i)
  );

  // behavioural RAM: filler 8'hA5 on lanes it does not drive
  always_comb begin
    logic [15:0] w;
    w = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : 16'h0000;
    sram_dq_i = 16'hA5A5;
    if (!ce_n && !oe_n && we_n) begin
      if (!bs_n[0]) sram_dq_i[7:0]  = w[7:0];
      if (!bs_n[1]) sram_dq_i[15:8] = w[15:8];
    end
  end

  always @(posedge we_n) begin
    if (!ce_n && dq_oe) begin
      logic [15:0] w;
      w = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : 16'h0000;
      if (!bs_n[0]) w[7:0]  = sram_dq_o[7:0];
      if (!bs_n[1]) w[15:8] = sram_dq_o[15:8];
      ram[int'(sram_addr)] = w;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected pin vector {ce,we,oe,bs[1:0],dq_oe,ready,rsp}
  task automatic pins(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {ce_n, we_n, oe_n, bs_n, dq_oe, req_ready, rsp_valid};
    chk(act == exp, tag, 32'(act), 32'(exp));
  endtask

  // R4 bus contention monitor on every cycle
  always @(negedge clk) if (rst_n && !finished)
    chk(!( !oe_n && dq_oe), "R4 drivers on while OE low", {oe_n, dq_oe}, 2'b10);

  task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    chk(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] w;
    issue(1'b1, a, d, be);
    if (be == 2'b00) begin
      pins("R7 zero-mask write idle", {3'b111, 2'b11, 1'b0, 1'b1, 1'b0});
      return;
    end
    w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
    if (be[0]) w[7:0]  = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    ref_mem[int'(a)] = w;
    for (int i = 0; i < SU; i++) begin
      pins("R5 write setup", {3'b011, ~be, 1'b1, 1'b0, 1'b0});
      chk(sram_dq_o == d && sram_addr == a, "R5 setup data/addr", {sram_addr, sram_dq_o}, {a, d});
      @(negedge clk);
    end
    for (int i = 0; i < PW; i++) begin
      pins("R5 write pulse R8", {3'b001, ~be, 1'b1, 1'b0, 1'b0});
      @(negedge clk);
    end
    pins("R5 write hold", {3'b011, ~be, 1'b1, 1'b0, 1'b0});
    chk(sram_dq_o == d, "R5 hold data", sram_dq_o, d);
    @(negedge clk);
    pins("R1 idle after write R8", {3'b111, 2'b11, 1'b0, 1'b1, 1'b0});
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] be);
    logic [15:0] e;
    issue(1'b0, a, 16'h0, be);
    if (be == 2'b00) begin
      pins("R7 zero-mask read", {3'b111, 2'b11, 1'b0, 1'b1, 1'b1});
      chk(rsp_rdata == 16'h0, "R7 zero-mask data", rsp_rdata, 0);
      return;
    end
    e = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
    if (!be[0]) e[7:0]  = 8'h00;
    if (!be[1]) e[15:8] = 8'h00;
    for (int i = 0; i < RD; i++) begin
      pins("R2 read strobes", {3'b010, ~be, 1'b0, 1'b0, 1'b0});
      chk(sram_addr == a, "R2 read address", sram_addr, a);
      @(negedge clk);
    end
    pins("R3 response pulse", {3'b111, 2'b11, 1'b0, 1'b0, 1'b1});
    chk(rsp_rdata == e, "R3 read data", rsp_rdata, e);
    @(negedge clk);
    for (int i = 1; i < TG; i++) begin
      pins("R4 turnaround", {3'b111, 2'b11, 1'b0, 1'b0, 1'b0});
      @(negedge clk);
    end
    pins("R4 ready after gap R3 single pulse", {3'b111, 2'b11, 1'b0, 1'b1, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    pins("R1 in reset", {3'b111, 2'b11, 1'b0, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    pins("R1 after reset", {3'b111, 2'b11, 1'b0, 1'b1, 1'b0});
    do_write(16'h0010, 16'h1234, 2'b11);
    do_read (16'h0010, 2'b11);
    do_write(16'h0010, 16'hABCD, 2'b01);   // R6 lower lane only
    do_read (16'h0010, 2'b11);
    do_write(16'h0010, 16'h5566, 2'b10);   // R6 upper lane only
    do_read (16'h0010, 2'b10);
    do_read (16'h0010, 2'b01);
    do_write(16'h0010, 16'hFFFF, 2'b00);   // R7
    do_read (16'h0010, 2'b00);
    do_read (16'h0010, 2'b11);
    do_write(16'hFFFF, 16'hC3A1, 2'b11);
    do_write(16'h0000, 16'h0F0F, 2'b11);
    do_read (16'hFFFF, 2'b11);
    do_write(16'hFFFF, 16'h7700, 2'b10);   // read then write back to back
    do_read (16'hFFFF, 2'b11);
    do_read (16'h0000, 2'b11);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule